// File: doc/BRIEF.md
# Gate supply lockout supervisor

This block sits between the digitized undervoltage comparators of a three-phase gate driver and its gate-control logic. It receives one "supply low" flag for the shared gate supply and one "bootstrap low" flag for each phase. It filters each flag against short glitches and produces the enables that the gate logic uses to permit switching.

A filtered fault on the shared supply removes every enable. When that supply has been good again for the full filter time, the enables return without any other action. A filtered bootstrap fault removes only the high-side enable of its own phase. The low side and the other phases keep running. After that fault clears, the high side stays locked until the phase's high-side PWM command shows a fresh low-to-high transition.

Each fault source has a sticky status bit. Software clears a bit with a write-one-to-clear strobe.

Top module: `gsup_uvlo_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `drive_en`, every bit of `hs_en` and every bit of `fault_status` are 0. The filtered supply flag starts in the faulted state. The filtered bootstrap flags start clear.
- R2: The filtered shared-supply flag takes a new level only after `main_low_raw` has held that level for `MAIN_DG` consecutive rising clock edges. It moves in both directions under this rule. A shorter excursion leaves it unchanged.
- R3: `drive_en` is 1 exactly while the filtered shared-supply flag is clear. While it is 0, every bit of `hs_en` is 0. Once the filtered flag clears, recovery needs no other input.
- R4: Each filtered bootstrap flag follows `boot_low_raw[k]` under the same symmetric rule, using `BOOT_DG` consecutive edges. An excursion shorter than that does not change `hs_en`.
- R5: A filtered bootstrap fault on phase k forces `hs_en[k]` to 0. It leaves `drive_en` and the high-side enables of the other phases unchanged.
- R6: After the filtered bootstrap flag of phase k clears, `hs_en[k]` stays 0 until a clock edge samples `hs_cmd[k]` high when it was low at the previous edge. `hs_en[k]` is 1 from that edge on, provided `drive_en` is 1.
- R7: A low-to-high transition of `hs_cmd[k]` that is sampled while the filtered bootstrap flag of phase k is still set does not unlock the phase.
- R8: `fault_status` bit 0 reports the shared supply and bit 1+k reports the bootstrap of phase k. A bit becomes 1 one clock after its filtered flag goes from clear to set. The faulted state held after reset does not set bit 0.
- R9: `status_clr[i]` held high at a clock edge clears `fault_status[i]` only if source i's filtered flag is clear at that edge. While the fault is active the strobe is ignored, and a new fault takes precedence over the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_low_raw | input | 1 | Unfiltered shared gate-supply low flag |
| boot_low_raw | input | NPH | Unfiltered bootstrap low flag, one per phase |
| hs_cmd | input | NPH | High-side PWM command, one per phase |
| status_clr | input | NPH+1 | Write-one-to-clear strobes for `fault_status` |
| drive_en | output | 1 | Global enable for all gate outputs |
| hs_en | output | NPH | Per-phase high-side enable |
| fault_status | output | NPH+1 | Sticky fault bits (bit 0 shared supply, bit 1+k phase k) |

## Verification
The bench aims at runs that are one cycle too short to pass the filter in either direction. A filter that counts non-consecutive samples, or that filters only one polarity, would let these runs through or keep one out. It drives PWM edges while a bootstrap fault is still filtered and after it clears. A design that latched an early edge would release the high side with no fresh command, and one that ignored the edge would never recover. It also fires clear strobes while a fault is active and in the same cycle a new fault appears. A wrong priority would lose a sticky bit or keep one that should have gone. A behavioural model compared on every clock, driven by a long pseudo-random phase, catches any cycle offset in enables or status.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;

    // Output of one flag filter: settled level and a one-cycle pulse when it turns faulted.
    typedef struct packed {
        logic flt;
        logic rise;
    } dg_out_t;

    // Low-to-high transition between the previous and the current sample.
    function automatic logic rise_seen(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    // Sticky bit update: a new fault sets it, a strobe clears it only once the fault is gone.
    function automatic logic sticky_next(input logic cur, input logic set,
                                         input logic clr, input logic active);
        return set | (cur & ~(clr & ~active));
    endfunction

endpackage

// File: rtl/uvlo_deglitch.sv
module uvlo_deglitch
    import uvlo_pkg::*;
#(
    parameter int unsigned LEN  = 4,
    parameter bit          INIT = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    raw,
    output dg_out_t q
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.flt   <= INIT;
            q.rise  <= 1'b0;
            run_cnt <= '0;
        end else if (raw == q.flt) begin
            run_cnt <= '0;
            q.rise  <= 1'b0;
        end else if (run_cnt == LAST) begin
            q.flt   <= raw;
            q.rise  <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
            q.rise  <= 1'b0;
        end
    end

    // R2 / R4: the settled level only moves to the level the raw flag had at the previous edge
    a_r2_filter_change: assert property (@(posedge clk) disable iff (rst)
        (q.flt != $past(q.flt)) |-> ($past(raw) == q.flt));

endmodule

// File: rtl/uvlo_phase_guard.sv
module uvlo_phase_guard
    import uvlo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boot_flt,
    input  logic hs_cmd,
    input  logic drive_ok,
    output logic hs_en
);
    logic lock;
    logic hs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock    <= 1'b0;
            hs_prev <= 1'b0;
        end else begin
            hs_prev <= hs_cmd;
            if (boot_flt)
                lock <= 1'b1;
            else if (lock && rise_seen(hs_cmd, hs_prev))
                lock <= 1'b0;
        end
    end

    assign hs_en = drive_ok & ~lock & ~boot_flt;

    // R5: one cycle after a filtered bootstrap fault the high side is still held off
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
        boot_flt |=> !hs_en);

    // R6 / R7: a locked phase is released only by a fresh command edge
    a_r6_edge_release: assert property (@(posedge clk) disable iff (rst)
        (hs_en && !$past(hs_en) && $past(lock)) |-> ($past(hs_cmd) && !$past(hs_prev)));

endmodule

// File: rtl/uvlo_status.sv
module uvlo_status
    import uvlo_pkg::*;
#(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_rise,
    input  logic [NSRC-1:0] src_act,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++)
                st[i] <= sticky_next(st[i], src_rise[i], clr[i], src_act[i]);
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R8: a new filtered fault is recorded one cycle later
        a_r8_set: assert property (@(posedge clk) disable iff (rst)
            src_rise[g] |=> st[g]);
        // R9: a strobe cannot clear a bit while its fault is active
        a_r9_hold_active: assert property (@(posedge clk) disable iff (rst)
            (src_act[g] && st[g]) |=> st[g]);
    end

endmodule

// File: rtl/gsup_uvlo_supervisor.sv
module gsup_uvlo_supervisor
    import uvlo_pkg::*;
#(
    parameter int unsigned NPH     = 3,
    parameter int unsigned MAIN_DG = 2000,
    parameter int unsigned BOOT_DG = 2000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           main_low_raw,
    input  logic [NPH-1:0] boot_low_raw,
    input  logic [NPH-1:0] hs_cmd,
    input  logic [NPH:0]   status_clr,
    output logic           drive_en,
    output logic [NPH-1:0] hs_en,
    output logic [NPH:0]   fault_status
);
    localparam int unsigned NSRC = NPH + 1;

    dg_out_t         main_q;
    dg_out_t         boot_q [NPH];
    logic [NSRC-1:0] src_rise;
    logic [NSRC-1:0] src_act;

    // Shared supply: starts faulted so that enables wait for a filtered good level
    uvlo_deglitch #(.LEN(MAIN_DG), .INIT(1'b1)) i_main_dg (
        .clk (clk),
        .rst (rst),
        .raw (main_low_raw),
        .q   (main_q)
    );

    assign drive_en    = ~main_q.flt;
    assign src_rise[0] = main_q.rise;
    assign src_act[0]  = main_q.flt;

    for (genvar k = 0; k < NPH; k++) begin : g_phase
        uvlo_deglitch #(.LEN(BOOT_DG), .INIT(1'b0)) i_boot_dg (
            .clk (clk),
            .rst (rst),
            .raw (boot_low_raw[k]),
            .q   (boot_q[k])
        );

        uvlo_phase_guard i_guard (
            .clk      (clk),
            .rst      (rst),
            .boot_flt (boot_q[k].flt),
            .hs_cmd   (hs_cmd[k]),
            .drive_ok (drive_en),
            .hs_en    (hs_en[k])
        );

        assign src_rise[k+1] = boot_q[k].rise;
        assign src_act[k+1]  = boot_q[k].flt;
    end

    uvlo_status #(.NSRC(NSRC)) i_status (
        .clk      (clk),
        .rst      (rst),
        .src_rise (src_rise),
        .src_act  (src_act),
        .clr      (status_clr),
        .st       (fault_status)
    );

    // R3: with the global enable removed no high side may be enabled
    a_r3_all_off: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (hs_en == '0));

endmodule

// File: tb/test_gsup_uvlo_supervisor.sv
`timescale 1ns/1ps
module test_gsup_uvlo_supervisor;
    localparam int NPH     = 3;
    localparam int NSRC    = NPH + 1;
    localparam int MAIN_DG = 5;
    localparam int BOOT_DG = 7;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           main_low_raw = 1'b1;
    logic [NPH-1:0] boot_low_raw = '0;
    logic [NPH-1:0] hs_cmd = '0;
    logic [NPH:0]   status_clr = '0;
    logic           drive_en;
    logic [NPH-1:0] hs_en;
    logic [NPH:0]   fault_status;

    int n_chk  = 0;
    int n_fail = 0;
    bit model_ok = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    int m_flt  [NSRC];
    int m_cnt  [NSRC];
    int m_rise [NSRC];
    int m_st   [NSRC];
    int m_lock [NPH];
    int m_prev [NPH];

    always #2.5 clk = ~clk;

    gsup_uvlo_supervisor #(.NPH(NPH), .MAIN_DG(MAIN_DG), .BOOT_DG(BOOT_DG)) i_gsup_uvlo_supervisor (
        .clk          (clk),
        .rst          (rst),
        .main_low_raw (main_low_raw),
        .boot_low_raw (boot_low_raw),
        .hs_cmd       (hs_cmd),
        .status_clr   (status_clr),
        .drive_en     (drive_en),
        .hs_en        (hs_en),
        .fault_status (fault_status)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int raw_of(input int s);
        return (s == 0) ? int'(main_low_raw) : int'(boot_low_raw[s-1]);
    endfunction

    function automatic int len_of(input int s);
        return (s == 0) ? MAIN_DG : BOOT_DG;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSRC; s++) begin
                m_flt[s] = (s == 0) ? 1 : 0;
                m_cnt[s] = 0; m_rise[s] = 0; m_st[s] = 0;
            end
            for (int k = 0; k < NPH; k++) begin
                m_lock[k] = 0; m_prev[k] = 0;
            end
        end else begin
            for (int s = 0; s < NSRC; s++) begin
                if (m_rise[s] != 0) m_st[s] = 1;
                else if (status_clr[s] && m_flt[s] == 0) m_st[s] = 0;
            end
            for (int k = 0; k < NPH; k++) begin
                if (m_flt[k+1] != 0) m_lock[k] = 1;
                else if (m_lock[k] != 0 && hs_cmd[k] && m_prev[k] == 0) m_lock[k] = 0;
                m_prev[k] = int'(hs_cmd[k]);
            end
            for (int s = 0; s < NSRC; s++) begin
                if (raw_of(s) == m_flt[s]) begin
                    m_cnt[s] = 0; m_rise[s] = 0;
                end else if (m_cnt[s] == len_of(s) - 1) begin
                    m_flt[s] = raw_of(s); m_rise[s] = raw_of(s); m_cnt[s] = 0;
                end else begin
                    m_cnt[s] = m_cnt[s] + 1; m_rise[s] = 0;
                end
            end
        end
        model_ok = 1'b1;
    end

    // compare with the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (model_ok && !done) begin
            int exp_hs;
            int exp_st;
            exp_hs = 0; exp_st = 0;
            for (int k = 0; k < NPH; k++)
                if (m_flt[0] == 0 && m_lock[k] == 0 && m_flt[k+1] == 0) exp_hs |= (1 << k);
            for (int s = 0; s < NSRC; s++)
                if (m_st[s] != 0) exp_st |= (1 << s);
            check("R3", "drive_en vs model", int'(drive_en), (m_flt[0] == 0) ? 1 : 0);
            check("R5", "hs_en vs model", int'(hs_en), exp_hs);
            check("R8", "fault_status vs model", int'(fault_status), exp_st);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int unsigned lfsr;
        lfsr = 32'h1d2c_3b4a;
        wait_n(4);
        check("R1", "drive_en in reset", int'(drive_en), 0);
        check("R1", "hs_en in reset", int'(hs_en), 0);
        check("R1", "fault_status in reset", int'(fault_status), 0);
        rst = 1'b0;
        wait_n(1);
        check("R1", "drive_en after release", int'(drive_en), 0);
        check("R1", "fault_status after release", int'(fault_status), 0);

        // R2: short good run on the shared supply is rejected
        main_low_raw = 1'b0; wait_n(MAIN_DG - 1);
        main_low_raw = 1'b1; wait_n(8);
        check("R2", "drive_en after short good run", int'(drive_en), 0);
        main_low_raw = 1'b0; wait_n(8);
        check("R2", "drive_en after full good run", int'(drive_en), 1);
        check("R8", "no status from reset fault", int'(fault_status), 0);

        hs_cmd = '1; wait_n(2);
        check("R5", "all high sides enabled", int'(hs_en), 7);

        // R4: short bootstrap glitch on phase 1
        boot_low_raw = 3'b010; wait_n(BOOT_DG - 1);
        boot_low_raw = 3'b000; wait_n(10);
        check("R4", "hs_en after short boot glitch", int'(hs_en), 7);
        check("R4", "status after short boot glitch", int'(fault_status), 0);

        // R5 / R8: real bootstrap fault on phase 1
        boot_low_raw = 3'b010; wait_n(10);
        check("R5", "only phase 1 high side off", int'(hs_en), 5);
        check("R5", "drive_en kept", int'(drive_en), 1);
        check("R8", "phase 1 status bit", int'(fault_status), 4);

        // R7: edge while fault still filtered
        hs_cmd[1] = 1'b0; wait_n(2);
        hs_cmd[1] = 1'b1; wait_n(2);
        check("R7", "edge during fault ignored", int'(hs_en[1]), 0);

        // R9: strobe while active is ignored
        status_clr = 4'b0100; wait_n(1);
        status_clr = '0; wait_n(1);
        check("R9", "clear ignored while active", int'(fault_status), 4);

        // R6: fault clears but no fresh edge yet
        boot_low_raw = 3'b000; wait_n(10);
        check("R6", "phase 1 locked without edge", int'(hs_en), 5);
        status_clr = 4'b0100; wait_n(1);
        status_clr = '0;
        check("R9", "clear accepted after fault", int'(fault_status), 0);
        hs_cmd[1] = 1'b0; wait_n(1);
        check("R6", "still locked on low command", int'(hs_en[1]), 0);
        hs_cmd[1] = 1'b1; wait_n(1);
        check("R6", "released by fresh edge", int'(hs_en), 7);

        // R3 / R9: shared supply fault with a clear strobe held
        status_clr = 4'b0001; main_low_raw = 1'b1; wait_n(8);
        check("R3", "drive_en off on supply fault", int'(drive_en), 0);
        check("R3", "all high sides off", int'(hs_en), 0);
        check("R9", "new fault beats strobe", int'(fault_status), 1);
        status_clr = '0; main_low_raw = 1'b0; wait_n(8);
        check("R3", "automatic recovery drive_en", int'(drive_en), 1);
        check("R3", "automatic recovery hs_en", int'(hs_en), 7);
        check("R8", "status kept after recovery", int'(fault_status), 1);
        status_clr = 4'b0001; wait_n(1);
        status_clr = '0;
        check("R9", "supply bit cleared", int'(fault_status), 0);

        // pseudo-random phase checked against the model
        for (int c = 0; c < 4000; c++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            if (lfsr[2:0] == 3'd0 && lfsr[20:18] == 3'd0) main_low_raw = ~main_low_raw;
            for (int k = 0; k < NPH; k++)
                if (lfsr[5+3*k +: 3] == 3'd0) boot_low_raw[k] = ~boot_low_raw[k];
            hs_cmd = lfsr[16:14] ^ hs_cmd & lfsr[23:21];
            status_clr = (lfsr[27:25] == 3'd0) ? lfsr[31:28] : '0;
            wait_n(1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 run did not finish: got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule